// File: doc/BRIEF.md
# Comma detect and byte aligner

This block sits behind a clock-recovery stage. It receives the recovered serial stream one bit at a time, each bit marked by a valid strobe. It groups the bits into 10-bit code groups. When synchronization is enabled, it watches every bit position for the negative-disparity K28.5 comma. When it finds one, it moves the word boundary so that the comma opens a new code group. It then flags that group with a one-cycle sync pulse.

Words leave the block on a fixed cadence of one per ten valid bits. Each word is announced by a one-cycle byte-clock enable. In the half-rate arrangement, consecutive words alternate between two enables. In the full-rate arrangement, every word uses the first enable and the second stays low.

A realignment never moves the cadence. The block holds the realigned word in a two-word window until the next regular slot. As a result, no byte-clock period is ever shortened.

Top module: `comma_aligner`

## Requirements
- R1: After reset, word_out, sync_out, bclk0 and bclk1 are all 0 until the first word is delivered.
- R2: Each word is strobed one clock after the valid bit whose 0-based count since reset is 10n+9. With sync_en low, the word holds the ten bits of that group, with the earliest-received bit in word_out[0].
- R3: The comma is the received sequence 0,0,1,1,1,1,1, which appears as word_out[6:0] = 7'b1111100. It is recognised at any bit position, and bits before the first received bit count as zeros. With sync_en high, the word that begins with the comma is delivered, and sync_out is high in the same cycle as that word's strobe.
- R4: With sync_en high, the words after a comma word are the consecutive 10-bit groups that follow the comma. Each word is the newest group completed at or before its strobe slot.
- R5: With sync_en low, sync_out stays 0 and no comma changes the word boundary.
- R6: A comma that already starts on the current boundary leaves the boundary and the latency unchanged, and still pulses sync_out.
- R7: Byte-clock enables and sync_out are high only in the strobe cycles of R2. Strobes are therefore exactly ten valid bits apart, and realignment never shortens that spacing.
- R8: With ddr_mode and full_rate both low, strobes alternate between the two enables, and the first word after reset uses bclk1. The two enables are never high together.
- R9: With ddr_mode low and full_rate high, every word strobes bclk0 and bclk1 stays low.
- R10: With ddr_mode high, full_rate is ignored and the enables behave as in R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_in | input | 1 | Recovered serial bit |
| bit_vld | input | 1 | bit_in carries a new bit this cycle |
| sync_en | input | 1 | Enables comma search and realignment |
| ddr_mode | input | 1 | Narrow double-rate interface selected; forces single-enable output |
| full_rate | input | 1 | Selects single full-rate enable when ddr_mode is low |
| word_out | output | 10 | Delivered code group, earliest bit in bit 0 |
| sync_out | output | 1 | One-cycle pulse with the comma word |
| bclk0 | output | 1 | Byte-clock enable, odd words in half-rate, every word in full-rate |
| bclk1 | output | 1 | Byte-clock enable, even words in half-rate, low in full-rate |

## Verification
The assertions take for granted that ddr_mode, full_rate and sync_en stay constant between resets. The alternation check and the sync-only-when-enabled check both reason about whole runs of words under one configuration. The stimulus respects this by fixing the configuration before each reset and holding it for the whole run.

Within each run, the bench drives filler from a shift-register generator, with commas planted at offsets that sweep every phase of the boundary. It leaves random idle cycles between valid bits, and it forces the first three bits to zero so that the assumed zero history cannot form a comma.

// File: rtl/comma_aligner.sv
module comma_aligner #(
  parameter int W = 10,
  parameter int CL = 7,
  parameter logic [CL-1:0] COMMA = 7'b1111100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bit_vld,
  input  logic         sync_en,
  input  logic         ddr_mode,
  input  logic         full_rate,
  output logic [W-1:0] word_out,
  output logic         sync_out,
  output logic         bclk0,
  output logic         bclk1
);
  localparam int WIN = 2 * W;
  localparam int CW  = $clog2(W);
  localparam int IW  = $clog2(WIN);

  logic [WIN-1:0] win;
  logic [WIN-1:0] win_n;
  logic [CW-1:0]  ec, lag, lag_n;
  logic [IW-1:0]  idx;
  logic           pend, sel, hit, emit, single;

  assign win_n  = {bit_in, win[WIN-1:1]};
  assign hit    = bit_vld && sync_en && (win_n[W +: CL] == COMMA);
  assign emit   = bit_vld && (ec == CW'(W - 1));
  assign lag_n  = hit ? CW'(W - 1) - ec : lag;
  assign idx    = IW'(W) - IW'(lag_n);
  assign single = ddr_mode | full_rate;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win      <= '0;
      ec       <= '0;
      lag      <= '0;
      pend     <= 1'b0;
      sel      <= 1'b1;
      word_out <= '0;
      sync_out <= 1'b0;
      bclk0    <= 1'b0;
      bclk1    <= 1'b0;
    end else begin
      sync_out <= 1'b0;
      bclk0    <= 1'b0;
      bclk1    <= 1'b0;
      if (bit_vld) begin
        win  <= win_n;
        lag  <= lag_n;
        ec   <= emit ? '0 : ec + 1'b1;
        pend <= hit ? !emit : (emit ? 1'b0 : pend);
      end
      if (emit) begin
        word_out <= win_n[idx +: W];
        sync_out <= sync_en && (pend || hit);
        sel      <= !sel;
        bclk0    <= single || !sel;
        bclk1    <= !single && sel;
      end
    end
  end
endmodule

module comma_aligner_chk #(
  parameter int W = 10,
  parameter int CL = 7,
  parameter logic [CL-1:0] COMMA = 7'b1111100
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bit_vld,
  input logic         sync_en,
  input logic         ddr_mode,
  input logic         full_rate,
  input logic [W-1:0] word_out,
  input logic         sync_out,
  input logic         bclk0,
  input logic         bclk1
);
  localparam int VW = $clog2(W + 1) + 1;
  logic [VW-1:0] vcnt;
  logic          last1;
  logic          strobe;

  assign strobe = bclk0 | bclk1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vcnt  <= '0;
      last1 <= 1'b0;
    end else begin
      vcnt <= (strobe ? '0 : vcnt) + VW'(bit_vld);
      if (strobe) last1 <= bclk1;
    end
  end

  p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> vcnt == VW'(W));
  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bclk0, bclk1}));
  p_alt1_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bclk1 |-> !last1);
  p_alt0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk0 && !$past(ddr_mode | full_rate)) |-> last1);
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ddr_mode | full_rate) |=> !bclk1);
  p_sync_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |-> (strobe && word_out[CL-1:0] == COMMA));
  p_no_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> !sync_out);
endmodule

bind comma_aligner comma_aligner_chk #(.W(W), .CL(CL), .COMMA(COMMA)) u_chk (.*);

// File: tb/comma_aligner_tb.sv
module comma_aligner_tb;
  localparam int NB = 600;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, bit_in, bit_vld, sync_en, ddr_mode, full_rate;
  logic [9:0] word_out;
  logic       sync_out, bclk0, bclk1;

  comma_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
    .sync_en(sync_en), .ddr_mode(ddr_mode), .full_rate(full_rate),
    .word_out(word_out), .sync_out(sync_out), .bclk0(bclk0), .bclk1(bclk1)
  );

  int checks = 0;
  int errors = 0;
  logic bits [0:NB-1];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  function automatic bit comma_at(input int p);
    return bits[p] == 1'b0 && bits[p+1] == 1'b0 && bits[p+2] && bits[p+3] &&
           bits[p+4] && bits[p+5] && bits[p+6];
  endfunction

  task automatic plant(input int q);
    bits[q] = 1'b0; bits[q+1] = 1'b0;
    for (int i = 2; i < 7; i++) bits[q+i] = 1'b1;
  endtask

  task automatic build(input int kind);
    for (int i = 0; i < NB; i++) bits[i] = rnd();
    bits[0] = 1'b0; bits[1] = 1'b0; bits[2] = 1'b0;
    if (kind == 1) for (int q = 25; q + 6 < NB - 20; q += 33) plant(q);
    if (kind == 2) for (int q = 20; q + 6 < NB - 20; q += 30) plant(q);
  endtask

  task automatic run(input bit se, input bit dd, input bit fr, input int kind,
                     input bit gaps, input string ctag);
    int t, curp, nstb, s;
    bit found, e_s, e_sy, e_b1;
    logic [9:0] e_w;
    string wtag;
    build(kind);
    sync_en = se; ddr_mode = dd; full_rate = fr;
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_out == 10'd0 && !sync_out && !bclk0 && !bclk1, "R1 reset state",
        {word_out, 3'b0, sync_out, bclk1, bclk0}, 16'h0);
    t = 0; curp = 0; found = 1'b0; nstb = 0; e_s = 1'b0;
    e_sy = 1'b0; e_b1 = 1'b0; e_w = '0; wtag = "";
    forever begin
      if (e_s) begin
        if (!dd && !fr)
          chk({bclk1, bclk0} == (e_b1 ? 2'b10 : 2'b01), "R8 half-rate enable",
              {14'b0, bclk1, bclk0}, {14'b0, e_b1, !e_b1});
        else
          chk({bclk1, bclk0} == 2'b01, ctag, {14'b0, bclk1, bclk0}, 16'h1);
        chk(word_out == e_w, wtag, {6'b0, word_out}, {6'b0, e_w});
        chk(sync_out == e_sy, se ? "R3 sync pulse" : "R5 sync held low",
            {15'b0, sync_out}, {15'b0, e_sy});
      end else begin
        chk(!bclk0 && !bclk1 && !sync_out, "R7 quiet between strobes",
            {13'b0, sync_out, bclk1, bclk0}, 16'h0);
      end
      e_s = 1'b0;
      if (t >= NB) break;
      bit_vld = gaps ? (rnd() | rnd()) : 1'b1;
      bit_in = bit_vld ? bits[t] : rnd();
      if (bit_vld) begin
        if (se && t >= 9 && comma_at(t - 9)) begin
          curp = t - 9;
          found = 1'b1;
        end
        if (t % 10 == 9) begin
          s = curp + 10 * ((t - 9 - curp) / 10);
          for (int i = 0; i < 10; i++) e_w[i] = bits[s+i];
          e_sy = se && found && (s == curp);
          e_b1 = (nstb % 2 == 0);
          e_s = 1'b1;
          nstb++;
          if (!se) wtag = "R2 unframed word";
          else if (kind == 2 && found && s == curp && curp % 10 == 0) wtag = "R6 aligned comma word";
          else wtag = "R4 realigned word";
        end
        t++;
      end
      @(negedge clk);
    end
    bit_vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
    sync_en = 1'b0; ddr_mode = 1'b0; full_rate = 1'b0;
    run(1'b0, 1'b0, 1'b0, 1, 1'b1, "R8");
    run(1'b1, 1'b0, 1'b0, 1, 1'b1, "R8");
    run(1'b1, 1'b0, 1'b1, 1, 1'b0, "R9 full-rate single enable");
    run(1'b1, 1'b1, 1'b0, 1, 1'b1, "R10 ddr with full_rate low");
    run(1'b1, 1'b1, 1'b1, 1, 1'b0, "R10 ddr with full_rate high");
    run(1'b1, 1'b0, 1'b0, 2, 1'b1, "R8");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule